// File: doc/BRIEF.md
# DRAM Command Spacing Checker

This block watches the command stream that a memory controller sends to a four-bank double-data-rate DRAM. It keeps a record of which banks hold an open row and how long ago each relevant command was accepted. In the cycle a command is presented, it returns a legal or illegal verdict and a violation code. A controller can use it as a gate in front of the command pins, and a verification environment can use it as a monitor. All minimum spacings arrive on input ports as cycle counts, so one instance covers every speed grade and latency setting. Half the burst length is also an input, because the block uses it to find where write data ends.

Only commands judged legal change the record. An illegal command leaves the record exactly as it was, so the controller can retry the same command later. The block does not model data transfers and does not schedule refreshes.

Top module: `ddr_cmd_timing_chk`

## Requirements
- R1: Command op codes are 0 no-operation, 1 activate, 2 read, 3 write, 4 precharge one bank, 5 precharge all banks, 6 auto-refresh, and 7 is unused. Codes 0 and 7, and any cycle with `cmd_valid` low, raise neither `chk_ok` nor `chk_err`. For every other op exactly one of the two is raised in the same cycle, and `chk_code` is 0 exactly when `chk_ok` is high.
- R2: Code 2 (bank state) is reported for a read or write to a closed bank, an activate to an open bank, and an auto-refresh while any bank is open.
- R3: A read needs `t_rcd_rd` cycles after its bank's activate, and a write needs `t_rcd_wr` cycles. The two limits are independent. A shortfall reports code 3.
- R4: A precharge of an open bank, or a precharge-all whose set of open banks includes such a bank, is legal only when two conditions hold: at least `t_ras` cycles have passed since that bank's activate, and at least `t_burst_half + t_wr` cycles have passed since its last write. Otherwise it reports code 4.
- R5: An activate, or an auto-refresh counted against every bank, is legal only when each of the following waits has passed for the bank: `t_rc` since its activate, `t_rp` since its precharge, `t_burst_half + t_dal` since a write with auto-precharge, and `t_burst_half + t_rp` since a read with auto-precharge. Otherwise it reports code 5. A column command with `cmd_autopre` high closes its bank.
- R6: Two activates to any banks must be at least `t_rrd` cycles apart; otherwise code 6.
- R7: Two column commands (read or write, any banks) must be at least `t_ccd` cycles apart; otherwise code 7.
- R8: A read must come at least `t_burst_half + t_cdlr` cycles after the last write; otherwise code 8.
- R9: For `t_rfc` cycles after an accepted auto-refresh, every command other than no-operation reports code 1.
- R10: An illegal command changes no bank state and restarts no spacing window.
- R11: When several rules are broken at once, the reported code follows this order: 1 first, then 2, then the bank-timing code (3, 4 or 5), then 6, 7 and 8.
- R12: A precharge to a closed bank is legal and has no effect; in particular it starts no `t_rp` wait. A precharge-all closes every open bank.
- R13: After reset all banks are closed and no wait is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | Command op code (R1) |
| cmd_bank | input | BANK_W | Target bank |
| cmd_autopre | input | 1 | Auto-precharge with a read or write |
| t_rcd_rd | input | TW | Activate to read, cycles |
| t_rcd_wr | input | TW | Activate to write, cycles |
| t_ras | input | TW | Activate to precharge, cycles |
| t_rc | input | TW | Activate to activate on one bank, cycles |
| t_rp | input | TW | Precharge to activate, cycles |
| t_rrd | input | TW | Activate to activate across banks, cycles |
| t_wr | input | TW | End of write data to precharge, cycles |
| t_dal | input | TW | End of write data to activate after auto-precharge, cycles |
| t_cdlr | input | TW | End of write data to read, cycles |
| t_ccd | input | TW | Column command to column command, cycles |
| t_rfc | input | TW | Auto-refresh busy time, cycles |
| t_burst_half | input | TW | Half the burst length, cycles |
| chk_ok | output | 1 | Presented command is legal |
| chk_err | output | 1 | Presented command is illegal |
| chk_code | output | 4 | Violation code, 0 when legal |

## Verification
The hardest situations to reach are the ones where two windows overlap on the same bank and only one of them decides the outcome. Examples are write recovery hidden under the open-row minimum, write-with-auto-precharge recovery hidden under the row cycle, and a read that misses both its activate delay and its write turnaround. Each directed scenario shrinks the competing timing inputs, for example a row-open minimum of 2 cycles, so that the window under test is the one that binds. It then presents commands exactly one cycle before and at the expected boundary. To test that an illegal command leaves no trace, the stimulus follows it with commands whose verdict would differ if the record had changed.

// File: rtl/ddrchk_pkg.sv
package ddrchk_pkg;

    // width of each timing input, in bits
    localparam int TW = 6;
    // window counters must hold the sum of two timing values
    localparam int WW = TW + 2;

    typedef logic [TW-1:0] tval_t;
    typedef logic [WW-1:0] wcnt_t;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_ACT  = 3'd1,
        OP_RD   = 3'd2,
        OP_WR   = 3'd3,
        OP_PRE  = 3'd4,
        OP_PREA = 3'd5,
        OP_REF  = 3'd6,
        OP_RSVD = 3'd7
    } cmd_op_e;

    typedef enum logic [3:0] {
        V_NONE      = 4'd0,
        V_RFC       = 4'd1,
        V_STATE     = 4'd2,
        V_RCD       = 4'd3,
        V_PRE_EARLY = 4'd4,
        V_ACT_EARLY = 4'd5,
        V_RRD       = 4'd6,
        V_CCD       = 4'd7,
        V_WTR       = 4'd8
    } viol_e;

    // per-bank readiness seen by the verdict logic
    typedef struct packed {
        logic is_open;
        logic rd_ok;
        logic wr_ok;
        logic pre_ok;
        logic act_ok;
    } bank_flags_t;

    // counter load for a span of n cycles: legal again n cycles after the command
    function automatic wcnt_t win(input wcnt_t span);
        return (span == '0) ? '0 : wcnt_t'(span - 1'b1);
    endfunction

    // one cycle of countdown, saturating at zero
    function automatic wcnt_t step(input wcnt_t c);
        return (c == '0) ? '0 : wcnt_t'(c - 1'b1);
    endfunction

    function automatic wcnt_t wmax(input wcnt_t a, input wcnt_t b);
        return (a > b) ? a : b;
    endfunction

    function automatic wcnt_t ext(input tval_t v);
        return wcnt_t'(v);
    endfunction

endpackage

// File: rtl/ddrchk_bank.sv
module ddrchk_bank
    import ddrchk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        upd,
    input  cmd_op_e     op,
    input  logic        ap,
    input  tval_t       t_rcd_rd,
    input  tval_t       t_rcd_wr,
    input  tval_t       t_ras,
    input  tval_t       t_rc,
    input  tval_t       t_rp,
    input  tval_t       t_wr,
    input  tval_t       t_dal,
    input  tval_t       t_blh,
    output bank_flags_t flags
);

    logic  open_q;
    wcnt_t rd_q, wr_q, pre_q, act_q;
    wcnt_t blh;

    assign blh = ext(t_blh);

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            rd_q   <= '0;
            wr_q   <= '0;
            pre_q  <= '0;
            act_q  <= '0;
        end else begin
            rd_q  <= step(rd_q);
            wr_q  <= step(wr_q);
            pre_q <= step(pre_q);
            act_q <= step(act_q);
            if (upd) begin
                case (op)
                    OP_ACT: begin
                        open_q <= 1'b1;
                        rd_q   <= win(ext(t_rcd_rd));
                        wr_q   <= win(ext(t_rcd_wr));
                        pre_q  <= win(ext(t_ras));
                        act_q  <= wmax(step(act_q), win(ext(t_rc)));
                    end
                    OP_RD: begin
                        if (ap) begin
                            open_q <= 1'b0;
                            act_q  <= wmax(step(act_q), win(blh + ext(t_rp)));
                        end
                    end
                    OP_WR: begin
                        pre_q <= wmax(step(pre_q), win(blh + ext(t_wr)));
                        if (ap) begin
                            open_q <= 1'b0;
                            act_q  <= wmax(step(act_q), win(blh + ext(t_dal)));
                        end
                    end
                    OP_PRE, OP_PREA: begin
                        if (open_q) begin
                            open_q <= 1'b0;
                            act_q  <= wmax(step(act_q), win(ext(t_rp)));
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        flags.is_open = open_q;
        flags.rd_ok   = (rd_q == '0);
        flags.wr_ok   = (wr_q == '0);
        flags.pre_ok  = (pre_q == '0);
        flags.act_ok  = (act_q == '0);
    end

endmodule

// File: rtl/ddrchk_spacing.sv
module ddrchk_spacing
    import ddrchk_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    upd,
    input  cmd_op_e op,
    input  tval_t   t_rrd,
    input  tval_t   t_ccd,
    input  tval_t   t_cdlr,
    input  tval_t   t_rfc,
    input  tval_t   t_blh,
    output logic    rrd_ok,
    output logic    ccd_ok,
    output logic    wtr_ok,
    output logic    rfc_ok
);

    wcnt_t rrd_q, ccd_q, wtr_q, rfc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rrd_q <= '0;
            ccd_q <= '0;
            wtr_q <= '0;
            rfc_q <= '0;
        end else begin
            rrd_q <= step(rrd_q);
            ccd_q <= step(ccd_q);
            wtr_q <= step(wtr_q);
            rfc_q <= step(rfc_q);
            if (upd) begin
                case (op)
                    OP_ACT: rrd_q <= win(ext(t_rrd));
                    OP_RD:  ccd_q <= win(ext(t_ccd));
                    OP_WR: begin
                        ccd_q <= win(ext(t_ccd));
                        wtr_q <= wmax(step(wtr_q), win(ext(t_blh) + ext(t_cdlr)));
                    end
                    OP_REF: rfc_q <= win(ext(t_rfc));
                    default: ;
                endcase
            end
        end
    end

    assign rrd_ok = (rrd_q == '0);
    assign ccd_ok = (ccd_q == '0);
    assign wtr_ok = (wtr_q == '0);
    assign rfc_ok = (rfc_q == '0);

endmodule

// File: rtl/ddrchk_judge.sv
module ddrchk_judge
    import ddrchk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W = $clog2(NUM_BANKS)
) (
    input  logic              cmd_valid,
    input  cmd_op_e           op,
    input  logic [BANK_W-1:0] bank,
    input  bank_flags_t       flags [NUM_BANKS],
    input  logic              rrd_ok,
    input  logic              ccd_ok,
    input  logic              wtr_ok,
    input  logic              rfc_ok,
    output logic              accept,
    output logic              reject,
    output viol_e             code
);

    logic        issued;
    logic        all_idle, all_act_ok, open_pre_ok;
    bank_flags_t sel;

    assign issued = cmd_valid && (op != OP_NOP) && (op != OP_RSVD);

    always_comb begin
        all_idle    = 1'b1;
        all_act_ok  = 1'b1;
        open_pre_ok = 1'b1;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (flags[i].is_open) begin
                all_idle = 1'b0;
                if (!flags[i].pre_ok) open_pre_ok = 1'b0;
            end
            if (!flags[i].act_ok) all_act_ok = 1'b0;
        end
    end

    always_comb begin
        sel  = flags[bank];
        code = V_NONE;
        if (issued) begin
            if (!rfc_ok) begin
                code = V_RFC;
            end else begin
                case (op)
                    OP_ACT: begin
                        if (sel.is_open)      code = V_STATE;
                        else if (!sel.act_ok) code = V_ACT_EARLY;
                        else if (!rrd_ok)     code = V_RRD;
                    end
                    OP_RD: begin
                        if (!sel.is_open)     code = V_STATE;
                        else if (!sel.rd_ok)  code = V_RCD;
                        else if (!ccd_ok)     code = V_CCD;
                        else if (!wtr_ok)     code = V_WTR;
                    end
                    OP_WR: begin
                        if (!sel.is_open)     code = V_STATE;
                        else if (!sel.wr_ok)  code = V_RCD;
                        else if (!ccd_ok)     code = V_CCD;
                    end
                    OP_PRE: begin
                        if (sel.is_open && !sel.pre_ok) code = V_PRE_EARLY;
                    end
                    OP_PREA: begin
                        if (!open_pre_ok) code = V_PRE_EARLY;
                    end
                    OP_REF: begin
                        if (!all_idle)        code = V_STATE;
                        else if (!all_act_ok) code = V_ACT_EARLY;
                    end
                    default: code = V_NONE;
                endcase
            end
        end
    end

    assign accept = issued && (code == V_NONE);
    assign reject = issued && (code != V_NONE);

endmodule

// File: rtl/ddr_cmd_timing_chk.sv
module ddr_cmd_timing_chk
    import ddrchk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic              cmd_autopre,
    input  logic [TW-1:0]     t_rcd_rd,
    input  logic [TW-1:0]     t_rcd_wr,
    input  logic [TW-1:0]     t_ras,
    input  logic [TW-1:0]     t_rc,
    input  logic [TW-1:0]     t_rp,
    input  logic [TW-1:0]     t_rrd,
    input  logic [TW-1:0]     t_wr,
    input  logic [TW-1:0]     t_dal,
    input  logic [TW-1:0]     t_cdlr,
    input  logic [TW-1:0]     t_ccd,
    input  logic [TW-1:0]     t_rfc,
    input  logic [TW-1:0]     t_burst_half,
    output logic              chk_ok,
    output logic              chk_err,
    output logic [3:0]        chk_code
);

    cmd_op_e               op_e;
    bank_flags_t           flags [NUM_BANKS];
    logic [NUM_BANKS-1:0]  open_vec;
    logic                  accept, reject;
    logic                  rrd_ok, ccd_ok, wtr_ok, rfc_ok;
    viol_e                 code;

    assign op_e = cmd_op_e'(cmd_op);

    for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
        logic touch;
        assign touch = accept && ((op_e == OP_PREA) || (cmd_bank == BANK_W'(gi)));

        ddrchk_bank u_bank (
            .clk      (clk),
            .rst      (rst),
            .upd      (touch),
            .op       (op_e),
            .ap       (cmd_autopre),
            .t_rcd_rd (t_rcd_rd),
            .t_rcd_wr (t_rcd_wr),
            .t_ras    (t_ras),
            .t_rc     (t_rc),
            .t_rp     (t_rp),
            .t_wr     (t_wr),
            .t_dal    (t_dal),
            .t_blh    (t_burst_half),
            .flags    (flags[gi])
        );

        assign open_vec[gi] = flags[gi].is_open;
    end

    ddrchk_spacing u_spacing (
        .clk    (clk),
        .rst    (rst),
        .upd    (accept),
        .op     (op_e),
        .t_rrd  (t_rrd),
        .t_ccd  (t_ccd),
        .t_cdlr (t_cdlr),
        .t_rfc  (t_rfc),
        .t_blh  (t_burst_half),
        .rrd_ok (rrd_ok),
        .ccd_ok (ccd_ok),
        .wtr_ok (wtr_ok),
        .rfc_ok (rfc_ok)
    );

    ddrchk_judge #(.NUM_BANKS(NUM_BANKS)) u_judge (
        .cmd_valid (cmd_valid),
        .op        (op_e),
        .bank      (cmd_bank),
        .flags     (flags),
        .rrd_ok    (rrd_ok),
        .ccd_ok    (ccd_ok),
        .wtr_ok    (wtr_ok),
        .rfc_ok    (rfc_ok),
        .accept    (accept),
        .reject    (reject),
        .code      (code)
    );

    assign chk_ok   = accept;
    assign chk_err  = reject;
    assign chk_code = code;

endmodule

// File: rtl/ddrchk_props.sv
module ddrchk_props
    import ddrchk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W = $clog2(NUM_BANKS)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cmd_valid,
    input logic [2:0]           cmd_op,
    input logic [BANK_W-1:0]    cmd_bank,
    input logic                 chk_ok,
    input logic                 chk_err,
    input logic [3:0]           chk_code,
    input logic [TW-1:0]        t_rrd,
    input logic [TW-1:0]        t_ccd,
    input logic [TW-1:0]        t_rfc,
    input logic [NUM_BANKS-1:0] bank_open
);

    logic is_col;
    logic is_real;
    assign is_col  = (cmd_op == OP_RD) || (cmd_op == OP_WR);
    assign is_real = (cmd_op != OP_NOP) && (cmd_op != OP_RSVD);

    // R2: column command to a closed bank is refused
    p_col_closed_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && is_col && !bank_open[cmd_bank]) |-> chk_err);

    // R2: activate to an open bank is refused
    p_act_open_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_ACT && bank_open[cmd_bank]) |-> chk_err);

    // R2: refresh with any bank open is refused
    p_ref_open_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_REF && (|bank_open)) |-> chk_err);

    // R6: back-to-back activates with a spacing above one
    p_rrd_gap_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(chk_ok) && $past(cmd_op) == OP_ACT
         && $past(t_rrd) > 1 && $stable(t_rrd)
         && cmd_valid && cmd_op == OP_ACT) |-> chk_err);

    // R7: back-to-back column commands with a spacing above one
    p_ccd_gap_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(chk_ok)
         && ($past(cmd_op) == OP_RD || $past(cmd_op) == OP_WR)
         && $past(t_ccd) > 1 && $stable(t_ccd)
         && cmd_valid && is_col) |-> chk_err);

    // R9: the cycle after an accepted refresh is blocked
    p_rfc_block_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(chk_ok) && $past(cmd_op) == OP_REF
         && $past(t_rfc) > 1 && $stable(t_rfc)
         && cmd_valid && is_real) |-> (chk_err && chk_code == 4'd1));

    // R10: a refused command leaves the open-bank set unchanged
    p_refused_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        chk_err |=> (bank_open == $past(bank_open)));

endmodule

bind ddr_cmd_timing_chk ddrchk_props #(.NUM_BANKS(NUM_BANKS)) u_props (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_bank  (cmd_bank),
    .chk_ok    (chk_ok),
    .chk_err   (chk_err),
    .chk_code  (chk_code),
    .t_rrd     (t_rrd),
    .t_ccd     (t_ccd),
    .t_rfc     (t_rfc),
    .bank_open (open_vec)
);

// File: tb/tb_ddr_cmd_timing_chk.sv
module tb_ddr_cmd_timing_chk;

    localparam int CLK_P = 10;

    localparam logic [2:0] C_NOP  = 3'd0;
    localparam logic [2:0] C_ACT  = 3'd1;
    localparam logic [2:0] C_RD   = 3'd2;
    localparam logic [2:0] C_WR   = 3'd3;
    localparam logic [2:0] C_PRE  = 3'd4;
    localparam logic [2:0] C_PREA = 3'd5;
    localparam logic [2:0] C_REF  = 3'd6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [1:0] cmd_bank = 2'd0;
    logic       cmd_autopre = 1'b0;
    logic [5:0] t_rcd_rd, t_rcd_wr, t_ras, t_rc, t_rp, t_rrd;
    logic [5:0] t_wr, t_dal, t_cdlr, t_ccd, t_rfc, t_burst_half;
    logic       chk_ok, chk_err;
    logic [3:0] chk_code;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    ddr_cmd_timing_chk dut (
        .clk          (clk),
        .rst          (rst),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .cmd_bank     (cmd_bank),
        .cmd_autopre  (cmd_autopre),
        .t_rcd_rd     (t_rcd_rd),
        .t_rcd_wr     (t_rcd_wr),
        .t_ras        (t_ras),
        .t_rc         (t_rc),
        .t_rp         (t_rp),
        .t_rrd        (t_rrd),
        .t_wr         (t_wr),
        .t_dal        (t_dal),
        .t_cdlr       (t_cdlr),
        .t_ccd        (t_ccd),
        .t_rfc        (t_rfc),
        .t_burst_half (t_burst_half),
        .chk_ok       (chk_ok),
        .chk_err      (chk_err),
        .chk_code     (chk_code)
    );

    task automatic set_defaults();
        t_rcd_rd = 6'd6;  t_rcd_wr = 6'd4;  t_ras = 6'd13; t_rc  = 6'd18;
        t_rp     = 6'd5;  t_rrd    = 6'd4;  t_wr  = 6'd4;  t_dal = 6'd9;
        t_cdlr   = 6'd3;  t_ccd    = 6'd1;  t_rfc = 6'd19; t_burst_half = 6'd2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cmd_valid = 1'b0;
        set_defaults();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic gap(input int n);
        repeat (n) @(posedge clk);
    endtask

    // presents one command for one cycle and checks the verdict before the edge
    task automatic issue(input logic [2:0] op, input int bank, input logic ap,
                         input int exp_code, input string tag);
        logic real_cmd, eok, eerr;
        @(negedge clk);
        cmd_valid   = 1'b1;
        cmd_op      = op;
        cmd_bank    = 2'(bank);
        cmd_autopre = ap;
        #1;
        real_cmd = (op != C_NOP) && (op != 3'd7);
        eok  = real_cmd && (exp_code == 0);
        eerr = real_cmd && (exp_code != 0);
        checks++;
        if (chk_ok !== eok || chk_err !== eerr || chk_code !== 4'(exp_code)) begin
            errors++;
            $display("FAIL %s: ok=%0b err=%0b code=%0d expected ok=%0b err=%0b code=%0d",
                     tag, chk_ok, chk_err, chk_code, eok, eerr, exp_code);
        end
        @(posedge clk);
        #1;
        cmd_valid   = 1'b0;
        cmd_op      = C_NOP;
        cmd_autopre = 1'b0;
    endtask

    // activate delays, write turnaround, open-row minimum, activate spacing
    task automatic scen_row_cycle();
        do_reset();
        issue(C_RD,  0, 1'b0, 2, "R13 closed after reset");
        issue(C_ACT, 0, 1'b0, 0, "R13 no pending wait");        // t0
        gap(2);
        issue(C_WR,  0, 1'b0, 3, "R3 write before t_rcd_wr");   // t3
        issue(C_WR,  0, 1'b0, 0, "R3 write at t_rcd_wr");       // t4
        issue(C_RD,  0, 1'b0, 3, "R11 rcd ahead of turnaround");// t5
        issue(C_RD,  0, 1'b0, 8, "R8 read inside turnaround");  // t6
        gap(2);
        issue(C_RD,  0, 1'b0, 0, "R8 read at turnaround end");  // t9
        issue(C_PRE, 0, 1'b0, 4, "R4 precharge before t_ras");  // t10
        gap(2);
        issue(C_PRE, 0, 1'b0, 0, "R4 precharge at t_ras");      // t13
        issue(C_ACT, 0, 1'b0, 5, "R5 activate before t_rc");    // t14
        issue(C_ACT, 1, 1'b0, 0, "R6 other bank activate");     // t15
        issue(C_ACT, 0, 1'b0, 5, "R11 row wait ahead of rrd");  // t16
        gap(1);
        issue(C_ACT, 0, 1'b0, 6, "R6 activate before t_rrd");   // t18
        issue(C_ACT, 0, 1'b0, 0, "R6 activate at t_rrd");       // t19
    endtask

    // write recovery, and a refused command leaving no trace
    task automatic scen_write_recovery();
        do_reset();
        t_ras = 6'd2;
        issue(C_ACT, 1, 1'b0, 0, "R4 setup activate");          // t0
        gap(3);
        issue(C_WR,  1, 1'b0, 0, "R4 write");                   // t4
        gap(4);
        issue(C_PRE, 1, 1'b0, 4, "R4 precharge inside t_wr");   // t9
        issue(C_PRE, 1, 1'b0, 0, "R4 precharge after t_wr");    // t10
        issue(C_ACT, 0, 1'b0, 0, "R10 activate bank 0");        // t11
        issue(C_ACT, 2, 1'b0, 6, "R10 refused activate");       // t12
        issue(C_RD,  2, 1'b0, 2, "R10 bank 2 still closed");    // t13
        gap(1);
        issue(C_ACT, 2, 1'b0, 0, "R10 rrd not restarted");      // t15
    endtask

    // auto-precharge recovery on write and read
    task automatic scen_auto_precharge();
        do_reset();
        t_rc = 6'd2;
        issue(C_ACT, 2, 1'b0, 0, "R5 setup activate");          // t0
        gap(3);
        issue(C_WR,  2, 1'b1, 0, "R5 write with auto-precharge");// t4
        issue(C_RD,  2, 1'b0, 2, "R2 bank closed by auto-precharge"); // t5
        gap(8);
        issue(C_ACT, 2, 1'b0, 5, "R5 activate inside t_dal");   // t14
        issue(C_ACT, 2, 1'b0, 0, "R5 activate after t_dal");    // t15

        do_reset();
        t_rc  = 6'd2;
        t_ras = 6'd2;
        issue(C_ACT, 0, 1'b0, 0, "R5 setup activate");          // t0
        gap(5);
        issue(C_RD,  0, 1'b1, 0, "R5 read with auto-precharge");// t6
        gap(5);
        issue(C_ACT, 0, 1'b0, 5, "R5 activate before read-ap recovery"); // t12
        issue(C_ACT, 0, 1'b0, 0, "R5 activate after read-ap recovery");  // t13
    endtask

    // refresh entry conditions and busy time
    task automatic scen_refresh();
        do_reset();
        issue(C_ACT, 3, 1'b0, 0, "R9 setup activate");          // t0
        issue(C_REF, 0, 1'b0, 2, "R2 refresh with open bank");  // t1
        gap(11);
        issue(C_PRE, 3, 1'b0, 0, "R9 close bank");             // t13
        issue(C_REF, 0, 1'b0, 5, "R5 refresh before row wait"); // t14
        gap(3);
        issue(C_REF, 0, 1'b0, 0, "R9 refresh accepted");        // t18
        issue(C_ACT, 0, 1'b0, 1, "R9 activate during refresh"); // t19
        issue(C_RD,  0, 1'b0, 1, "R11 refresh busy ahead of state"); // t20
        issue(C_NOP, 0, 1'b0, 0, "R1 no-operation gives no verdict"); // t21
        gap(14);
        issue(C_ACT, 0, 1'b0, 1, "R9 last blocked cycle");      // t36
        issue(C_ACT, 0, 1'b0, 0, "R9 first free cycle");        // t37
    endtask

    // column spacing and precharge-all
    task automatic scen_column_prea();
        do_reset();
        t_ccd = 6'd3;
        issue(C_ACT,  0, 1'b0, 0, "R7 setup bank 0");           // t0
        gap(3);
        issue(C_ACT,  1, 1'b0, 0, "R7 setup bank 1");           // t4
        gap(5);
        issue(C_RD,   0, 1'b0, 0, "R7 first read");             // t10
        issue(C_RD,   1, 1'b0, 7, "R7 read inside t_ccd");      // t11
        gap(1);
        issue(C_RD,   1, 1'b0, 0, "R7 read at t_ccd");          // t13
        issue(C_PREA, 0, 1'b0, 4, "R12 precharge-all, bank 1 too young"); // t14
        gap(2);
        issue(C_PREA, 0, 1'b0, 0, "R12 precharge-all accepted");// t17
        issue(C_RD,   0, 1'b0, 2, "R12 bank 0 closed");         // t18
        issue(C_PRE,  2, 1'b0, 0, "R12 precharge of closed bank"); // t19
        issue(C_ACT,  2, 1'b0, 0, "R12 no rp wait from idle precharge"); // t20
        issue(C_RD,   1, 1'b0, 2, "R12 bank 1 closed");         // t21
        issue(3'd7,   0, 1'b0, 0, "R1 unused op gives no verdict"); // t22
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog: all requirements actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        set_defaults();
        scen_row_cycle();
        scen_write_recovery();
        scen_auto_precharge();
        scen_refresh();
        scen_column_prea();
        gap(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule